// File: doc/BRIEF.md
# Mode-Dependent Address and Vector Unit

This unit sits between a processor core and its memory bus and turns a logical address into a 24-bit physical address. The core can run either in a 16-bit compatibility mode or in a 24-bit long mode.

In compatibility mode, a page register supplies the upper address byte. In long mode, the full logical address goes straight through. The unit also holds two more registers:
- an interrupt-vector register, which is joined with a byte from the interrupting device to build a vector-table address when interrupt mode 2 is in force;
- a refresh counter, which steps on every opcode or prefix fetch.

The operating mode is held in a two-state machine with states MODE_COMPAT and MODE_LONG. Reset places it in MODE_COMPAT. Transition TO_LONG is taken from MODE_COMPAT on a clock edge where the mode request is high. Transition TO_COMPAT is taken from MODE_LONG on a clock edge where the request is low. Every other case keeps the state. The address and vector outputs are combinational from the registered state, the registers and the current inputs.

Top module: `addr_vec_unit`

## Requirements
- R1: After reset, the page, vector and refresh registers read zero and `long_mode_o` is 0 (MODE_COMPAT).
- R2: While `long_mode_o` is 0, `phys_addr_o` equals the page register in bits 23:16, followed by `addr_i[15:0]`. `addr_i[23:16]` has no effect.
- R3: While `long_mode_o` is 1, `phys_addr_o` equals `addr_i` in all 24 bits, whatever the page register holds.
- R4: A page write (`wr_page_i` high, data from `wr_data_i[7:0]`) updates the page register at the clock edge only if `long_mode_o` is 1 in that cycle. Otherwise the page register keeps its value.
- R5: `long_mode_o` becomes 1 one clock edge after `mode_long_i` is sampled high (TO_LONG). It becomes 0 one clock edge after `mode_long_i` is sampled low (TO_COMPAT).
- R6: Each clock edge with `opfetch_i` high adds one to refresh bits 6:0 modulo 128. Refresh bit 7 keeps its last written value.
- R7: A refresh write (`wr_rfsh_i`, data from `wr_data_i[7:0]`) in the same cycle as `opfetch_i` loads the written value, and no increment happens.
- R8: When `iack_i` is high and `im_sel_i` is 2, `vec_valid_o` is 1 and `vec_addr_o` equals the vector register in bits 23:8, with `dev_byte_i` in bits 7:0.
- R9: When `im_sel_i` is 0 or 1, `vec_valid_o` stays 0 even during `iack_i`. The vector register is a plain 16-bit register written from `wr_data_i` by `wr_vec_i` and read back on `vec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_long_i | input | 1 | Mode request: 1 selects long mode at the next edge |
| addr_i | input | 24 | Logical address (low 16 bits used in compatibility mode) |
| opfetch_i | input | 1 | Opcode or prefix fetch strobe |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| im_sel_i | input | 2 | Interrupt mode in force (0, 1 or 2) |
| dev_byte_i | input | 8 | Byte supplied by the interrupting device |
| wr_page_i | input | 1 | Page register write enable |
| wr_vec_i | input | 1 | Vector register write enable |
| wr_rfsh_i | input | 1 | Refresh counter write enable |
| wr_data_i | input | 16 | Write data (page and refresh use bits 7:0) |
| long_mode_o | output | 1 | 1 while the mode state is MODE_LONG |
| phys_addr_o | output | 24 | Physical address |
| vec_valid_o | output | 1 | Vector address valid (acknowledge in mode 2) |
| vec_addr_o | output | 24 | Vector-table address |
| page_o | output | 8 | Page register value |
| vec_o | output | 16 | Vector register value |
| rfsh_o | output | 8 | Refresh counter value |

## Verification
The bench builds the unit with its default parameters:
- an 8-bit page;
- a 16-bit logical window;
- a 16-bit vector register;
- an 8-bit device byte;
- a 7-bit refresh count.

With these widths, the wrap of the refresh count from 127 to 0 is only two fetches away from a written value. A write of 0xFF shows bit 7 surviving an increment. Since the full 24-bit address and vector widths are exercised at their default sizes, the page byte and the device byte can be told apart from the logical bits they are joined to.

// File: rtl/avu_pkg.sv
package avu_pkg;
    typedef enum logic {
        MODE_COMPAT = 1'b0,
        MODE_LONG   = 1'b1
    } avu_mode_e;

    localparam logic [1:0] IM_VECTORED = 2'd2;
endpackage

// File: rtl/avu_mode_fsm.sv
module avu_mode_fsm
    import avu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_req_i,
    output logic long_o
);
    avu_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_COMPAT: if (mode_req_i)  state_d = MODE_LONG;   // TO_LONG
            MODE_LONG:   if (!mode_req_i) state_d = MODE_COMPAT; // TO_COMPAT
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_COMPAT;
        else        state_q <= state_d;
    end

    always_comb begin
        long_o = (state_q == MODE_LONG);
    end

    AST_MODE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_req_i) |=> long_o); // R5
    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mode_req_i) |=> !long_o); // R5
endmodule

// File: rtl/avu_page_reg.sv
module avu_page_reg #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] data_i,
    output logic [PAGE_W-1:0] page_o
);
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              page_q <= '0;
        else if (wr_i && long_i) page_q <= data_i;
    end

    assign page_o = page_q;

    AST_PAGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !long_i) |=> $stable(page_o)); // R4
    AST_PAGE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && long_i && wr_i) |=> (page_o == $past(data_i))); // R4
endmodule

// File: rtl/avu_vec_reg.sv
module avu_vec_reg #(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [VEC_W-1:0] data_i,
    output logic [VEC_W-1:0] vec_o
);
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vec_q <= '0;
        else if (wr_i) vec_q <= data_i;
    end

    assign vec_o = vec_q;

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_i) |=> $stable(vec_o)); // R9
endmodule

// File: rtl/avu_rfsh.sv
module avu_rfsh #(
    parameter int CNT_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fetch_i,
    input  logic           wr_i,
    input  logic [CNT_W:0] data_i,
    output logic [CNT_W:0] rf_o
);
    logic [CNT_W:0] rf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rf_q <= '0;
        else if (wr_i)    rf_q <= data_i;
        else if (fetch_i) rf_q[CNT_W-1:0] <= rf_q[CNT_W-1:0] + CNT_W'(1);
    end

    assign rf_o = rf_q;

    AST_RFSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && fetch_i && !wr_i) |=>
        (rf_o[CNT_W-1:0] == $past(rf_o[CNT_W-1:0]) + CNT_W'(1))); // R6
    AST_RFSH_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_i) |=> (rf_o[CNT_W] == $past(rf_o[CNT_W]))); // R6
    AST_RFSH_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_i) |=> (rf_o == $past(data_i))); // R7
endmodule

// File: rtl/addr_vec_unit.sv
module addr_vec_unit
    import avu_pkg::*;
#(
    parameter int LOG_W    = 16,
    parameter int PAGE_W   = 8,
    parameter int VEC_W    = 16,
    parameter int DEV_W    = 8,
    parameter int RF_CNT_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_long_i,
    input  logic [LOG_W+PAGE_W-1:0] addr_i,
    input  logic                    opfetch_i,
    input  logic                    iack_i,
    input  logic [1:0]              im_sel_i,
    input  logic [DEV_W-1:0]        dev_byte_i,
    input  logic                    wr_page_i,
    input  logic                    wr_vec_i,
    input  logic                    wr_rfsh_i,
    input  logic [VEC_W-1:0]        wr_data_i,
    output logic                    long_mode_o,
    output logic [LOG_W+PAGE_W-1:0] phys_addr_o,
    output logic                    vec_valid_o,
    output logic [VEC_W+DEV_W-1:0]  vec_addr_o,
    output logic [PAGE_W-1:0]       page_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic [RF_CNT_W:0]       rfsh_o
);
    localparam int PHYS_W = LOG_W + PAGE_W;
    localparam int RF_W   = RF_CNT_W + 1;

    logic long_q;

    avu_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req_i (mode_long_i),
        .long_o     (long_q)
    );

    avu_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .long_i (long_q),
        .wr_i   (wr_page_i),
        .data_i (wr_data_i[PAGE_W-1:0]),
        .page_o (page_o)
    );

    avu_vec_reg #(.VEC_W(VEC_W)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_vec_i),
        .data_i (wr_data_i),
        .vec_o  (vec_o)
    );

    avu_rfsh #(.CNT_W(RF_CNT_W)) u_rfsh (
        .clk     (clk),
        .rst_n   (rst_n),
        .fetch_i (opfetch_i),
        .wr_i    (wr_rfsh_i),
        .data_i  (wr_data_i[RF_W-1:0]),
        .rf_o    (rfsh_o)
    );

    always_comb begin
        long_mode_o = long_q;
        if (long_q) phys_addr_o = addr_i;
        else        phys_addr_o = {page_o, addr_i[LOG_W-1:0]};
        vec_valid_o = iack_i && (im_sel_i == IM_VECTORED);
        vec_addr_o  = {vec_o, dev_byte_i};
    end

    AST_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        long_mode_o |-> (phys_addr_o == addr_i)); // R3
    AST_COMPAT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !long_mode_o |-> (phys_addr_o[PHYS_W-1:LOG_W] == page_o)); // R2
    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (im_sel_i != IM_VECTORED) |-> !vec_valid_o); // R9
endmodule

// File: tb/addr_vec_unit_tb.sv
module addr_vec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_long_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic        opfetch_i = 1'b0;
    logic        iack_i = 1'b0;
    logic [1:0]  im_sel_i = '0;
    logic [7:0]  dev_byte_i = '0;
    logic        wr_page_i = 1'b0;
    logic        wr_vec_i = 1'b0;
    logic        wr_rfsh_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        long_mode_o;
    logic [23:0] phys_addr_o;
    logic        vec_valid_o;
    logic [23:0] vec_addr_o;
    logic [7:0]  page_o;
    logic [15:0] vec_o;
    logic [7:0]  rfsh_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_vec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode_long_i(mode_long_i), .addr_i(addr_i),
        .opfetch_i(opfetch_i), .iack_i(iack_i), .im_sel_i(im_sel_i),
        .dev_byte_i(dev_byte_i), .wr_page_i(wr_page_i), .wr_vec_i(wr_vec_i),
        .wr_rfsh_i(wr_rfsh_i), .wr_data_i(wr_data_i), .long_mode_o(long_mode_o),
        .phys_addr_o(phys_addr_o), .vec_valid_o(vec_valid_o),
        .vec_addr_o(vec_addr_o), .page_o(page_o), .vec_o(vec_o), .rfsh_o(rfsh_o)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R1 page", {16'h0, page_o}, 24'h0);
        chk("R1 vec", {8'h0, vec_o}, 24'h0);
        chk("R1 rfsh", {16'h0, rfsh_o}, 24'h0);
        chk("R1 mode", {23'h0, long_mode_o}, 24'h0);
    endtask

    task automatic t_compat_lock();
        addr_i = 24'hAB1234;
        #1 chk("R2 compat addr", phys_addr_o, 24'h001234);
        wr_page_i = 1'b1; wr_data_i = 16'h005A;
        step();
        wr_page_i = 1'b0;
        chk("R4 page write dropped in compat", {16'h0, page_o}, 24'h0);
        chk("R2 upper logical ignored", phys_addr_o, 24'h001234);
    endtask

    task automatic t_long_mode();
        mode_long_i = 1'b1;
        step();
        chk("R5 TO_LONG", {23'h0, long_mode_o}, 24'h1);
        wr_page_i = 1'b1; wr_data_i = 16'h005A;
        step();
        wr_page_i = 1'b0;
        chk("R4 page write in long", {16'h0, page_o}, 24'h5A);
        chk("R3 long passthrough", phys_addr_o, 24'hAB1234);
        mode_long_i = 1'b0;
        step();
        chk("R5 TO_COMPAT", {23'h0, long_mode_o}, 24'h0);
        addr_i = 24'hFF9876;
        #1 chk("R2 page on top", phys_addr_o, 24'h5A9876);
    endtask

    task automatic t_refresh();
        wr_rfsh_i = 1'b1; wr_data_i = 16'h007E;
        step();
        wr_rfsh_i = 1'b0;
        opfetch_i = 1'b1;
        step();
        chk("R6 step", {16'h0, rfsh_o}, 24'h7F);
        step();
        chk("R6 wrap low bits", {16'h0, rfsh_o}, 24'h00);
        opfetch_i = 1'b0;
        wr_rfsh_i = 1'b1; wr_data_i = 16'h00FF;
        step();
        wr_rfsh_i = 1'b0;
        opfetch_i = 1'b1;
        step();
        chk("R6 bit7 kept", {16'h0, rfsh_o}, 24'h80);
        wr_rfsh_i = 1'b1; wr_data_i = 16'h0033;
        step();
        wr_rfsh_i = 1'b0;
        chk("R7 write wins", {16'h0, rfsh_o}, 24'h33);
        for (int i = 0; i < 5; i++) step();
        opfetch_i = 1'b0;
        chk("R6 five fetches", {16'h0, rfsh_o}, 24'h38);
        step();
        chk("R6 idle hold", {16'h0, rfsh_o}, 24'h38);
    endtask

    task automatic t_vector();
        wr_vec_i = 1'b1; wr_data_i = 16'h1234;
        step();
        wr_vec_i = 1'b0;
        chk("R9 vec readback", {8'h0, vec_o}, 24'h1234);
        dev_byte_i = 8'hA5; iack_i = 1'b1; im_sel_i = 2'd0;
        #1 chk("R9 mode0 no vector", {23'h0, vec_valid_o}, 24'h0);
        im_sel_i = 2'd1;
        #1 chk("R9 mode1 no vector", {23'h0, vec_valid_o}, 24'h0);
        im_sel_i = 2'd2;
        #1 chk("R8 valid", {23'h0, vec_valid_o}, 24'h1);
        chk("R8 vector address", vec_addr_o, 24'h1234A5);
        iack_i = 1'b0;
        #1 chk("R8 no ack", {23'h0, vec_valid_o}, 24'h0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_compat_lock();
        t_long_mode();
        t_refresh();
        t_vector();
        finish_run();
    end
endmodule